// File: doc/BRIEF.md
# Sensor Offset Cancellation Loop

This block removes a slowly varying DC offset from a stream of signed sensor samples. The samples arrive already decimated. A first-order IIR low-pass filter tracks the offset. The block subtracts a separately held "applied offset" from every accepted sample and passes the difference on as a high-pass result. After reset the estimator runs two timed fast phases, so that it converges quickly. A 3-bit select then picks one of four normal-mode filters, and its low bit turns on a step rate limiter between the estimate and the applied offset. While self-test is asserted the applied offset is frozen, but the startup timers keep running. A monitor integrates how often the applied offset sits beyond a positive or negative threshold, and latches an error flag.

Samples enter and results leave on valid/ready streams. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. The result register holds one entry. `in_ready` is high when that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new sample is taken. Filter coefficients, phase lengths, rate period, step, thresholds and limit are parameters.

Top module: `offset_loop`

## Requirements
- R1: A sample is accepted on an edge where `in_valid` and `in_ready` are both high. Its result appears on `out_data` with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold.
- R2: The result is the accepted sample minus the applied offset present at the accepting edge, saturated to the signed DW range.
- R3: On each accepted sample x, the estimate becomes floor((n1·x + n2·x_prev − d2·y_prev) / 2^FRAC), saturated to DW bits, with FRAC = 8. x_prev is the previous accepted sample and y_prev is the previous estimate; both are 0 after reset. Between samples the estimate does not change.
- R4: Counting clock edges since reset, edges 0..PH1−1 (PH1 = 400) use coefficient set 0, and the next PH2 = 200 edges use set 1. After that, set 2 + filt_sel[2:1] applies. The default sets have n1 = n2 = a and d2 = 2a − 256, with a = 128, 64, 32, 16, 8, 128 for sets 0 to 5. `init_done` goes high once PH1 + PH2 edges have passed, and stays high.
- R5: In the startup phases, or with filt_sel[0] = 0, the applied offset (`ofs_applied`) takes the value of the estimate one cycle after the estimate changes.
- R6: After startup with filt_sel[0] = 1, the applied offset changes only on rate ticks, which come once every RATE_CYC = 16 cycles. At each tick it moves toward the estimate by STEP = 4, or by the remaining distance if that is smaller.
- R7: While `self_test` is high, `ofs_applied` holds, in every phase and mode. The phase timers keep counting, and the estimator keeps filtering.
- R8: Every MON_CYC = 32 cycles the monitor counter goes up if the applied offset is above +1000, and down if it is below −1000. It saturates at 0 and at MON_LIMIT = 8. `off_err` rises after the count reaches the limit and stays high until reset.
- R9: A synchronous reset clears `out_valid`, the estimate, the applied offset, the timers, the monitor count, `off_err` and `init_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | High-pass result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | DW | Signed high-pass result |
| filt_sel | input | 3 | [2:1] normal filter select, [0] rate limit enable |
| self_test | input | 1 | Freeze the applied offset |
| init_done | output | 1 | Both startup phases completed |
| ofs_applied | output | DW | Offset currently subtracted |
| off_err | output | 1 | Sticky excess-offset error |

## Verification
The bench drives samples whose sums round negatively or overflow the result range, so a logical shift or a missing clamp shows up as a wrong high-pass value. It places samples inside each startup phase and under two normal selects. It checks `init_done` on the exact edge where the timer expires, even when self-test has been held since reset. A timer that stalled under self-test would raise it late. A rate limiter that stepped by the wrong amount or on the wrong cycles is caught by counting changes in a window that is a whole number of rate periods. The monitor is first driven negative for a long time before it is driven positive, so a counter that drifted below zero would delay the error flag. A flag that was not latched would drop once the offset turned negative again.

// File: rtl/offset_pkg.sv
package offset_pkg;
  typedef enum logic [1:0] {
    PH_FAST1 = 2'd0,
    PH_FAST2 = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;
endpackage

// File: rtl/offset_tick.sv
module offset_tick #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/offset_phase_ctl.sv
module offset_phase_ctl
  import offset_pkg::*;
#(
  parameter int PH1      = 400,
  parameter int PH2      = 200,
  parameter int RATE_CYC = 16,
  parameter int MON_CYC  = 32
) (
  input  logic   clk,
  input  logic   rst,
  output phase_e phase,
  output logic   rate_tick,
  output logic   mon_tick
);
  localparam int TOT = PH1 + PH2;
  localparam int CW  = $clog2(TOT + 1);
  localparam logic [CW-1:0] END1 = CW'(PH1);
  localparam logic [CW-1:0] END2 = CW'(TOT);

  logic [CW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)               age_q <= '0;
    else if (age_q != END2) age_q <= age_q + 1'b1;
  end

  always_comb begin
    if (age_q < END1)      phase = PH_FAST1;
    else if (age_q < END2) phase = PH_FAST2;
    else                   phase = PH_RUN;
  end

  offset_tick #(.PERIOD(RATE_CYC)) u_rate (.clk(clk), .rst(rst), .tick(rate_tick));
  offset_tick #(.PERIOD(MON_CYC))  u_mon  (.clk(clk), .rst(rst), .tick(mon_tick));
endmodule

// File: rtl/offset_iir.sv
module offset_iir #(
  parameter int DW   = 16,
  parameter int CWID = 12,
  parameter int FRAC = 8,
  parameter int NSET = 6,
  parameter int N1 [NSET] = '{128, 64, 32, 16, 8, 128},
  parameter int N2 [NSET] = '{128, 64, 32, 16, 8, 128},
  parameter int D2 [NSET] = '{0, -128, -192, -224, -240, 0}
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            smp_en,
  input  logic signed [DW-1:0]            x_in,
  input  logic [$clog2(NSET)-1:0]         set_idx,
  output logic signed [DW-1:0]            y_out
);
  localparam int ACCW = DW + CWID + 3;
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((1 << (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -MAXV - 1;

  logic signed [CWID-1:0] tab_n1 [NSET];
  logic signed [CWID-1:0] tab_n2 [NSET];
  logic signed [CWID-1:0] tab_d2 [NSET];

  for (genvar i = 0; i < NSET; i++) begin : g_coef
    assign tab_n1[i] = CWID'(N1[i]);
    assign tab_n2[i] = CWID'(N2[i]);
    assign tab_d2[i] = CWID'(D2[i]);
  end

  logic signed [DW-1:0]   xp_q, y_q;
  logic signed [CWID-1:0] c_n1, c_n2, c_d2;
  logic signed [ACCW-1:0] acc, shr;
  logic signed [DW-1:0]   y_new;

  always_comb begin
    if (32'(set_idx) < NSET) begin
      c_n1 = tab_n1[set_idx];
      c_n2 = tab_n2[set_idx];
      c_d2 = tab_d2[set_idx];
    end else begin
      c_n1 = '0;
      c_n2 = '0;
      c_d2 = '0;
    end
    acc = ACCW'(c_n1) * ACCW'(x_in)
        + ACCW'(c_n2) * ACCW'(xp_q)
        - ACCW'(c_d2) * ACCW'(y_q);
    shr = acc >>> FRAC;
    if (shr > MAXV)      y_new = MAXV[DW-1:0];
    else if (shr < MINV) y_new = MINV[DW-1:0];
    else                 y_new = shr[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xp_q <= '0;
      y_q  <= '0;
    end else if (smp_en) begin
      xp_q <= x_in;
      y_q  <= y_new;
    end
  end

  assign y_out = y_q;
endmodule

// File: rtl/offset_apply.sv
module offset_apply #(
  parameter int DW   = 16,
  parameter int STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] est,
  input  logic                 hold,
  input  logic                 limit_en,
  input  logic                 rate_tick,
  output logic signed [DW-1:0] ofs
);
  localparam logic signed [DW:0]   STEP_W = (DW+1)'(STEP);
  localparam logic signed [DW-1:0] STEP_N = DW'(STEP);

  logic signed [DW-1:0] ofs_q;
  logic signed [DW:0]   gap;

  assign gap = {est[DW-1], est} - {ofs_q[DW-1], ofs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q <= '0;
    end else if (!hold) begin
      if (!limit_en)          ofs_q <= est;
      else if (rate_tick) begin
        if (gap > STEP_W)       ofs_q <= ofs_q + STEP_N;
        else if (gap < -STEP_W) ofs_q <= ofs_q - STEP_N;
        else                    ofs_q <= est;
      end
    end
  end

  assign ofs = ofs_q;
endmodule

// File: rtl/offset_monitor.sv
module offset_monitor #(
  parameter int DW     = 16,
  parameter int POS_TH = 1000,
  parameter int NEG_TH = -1000,
  parameter int LIMIT  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic signed [DW-1:0] ofs,
  output logic                 err
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0]        TOP  = CW'(LIMIT);
  localparam logic signed [DW-1:0] POSV = DW'(POS_TH);
  localparam logic signed [DW-1:0] NEGV = DW'(NEG_TH);

  logic [CW-1:0] cnt_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (tick) begin
        if (ofs > POSV && cnt_q != TOP)       cnt_q <= cnt_q + 1'b1;
        else if (ofs < NEGV && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      if (cnt_q == TOP) err_q <= 1'b1;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/offset_loop.sv
module offset_loop
  import offset_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CWID      = 12,
  parameter int FRAC      = 8,
  parameter int NSET      = 6,
  parameter int N1 [NSET] = '{128, 64, 32, 16, 8, 128},
  parameter int N2 [NSET] = '{128, 64, 32, 16, 8, 128},
  parameter int D2 [NSET] = '{0, -128, -192, -224, -240, 0},
  parameter int PH1       = 400,
  parameter int PH2       = 200,
  parameter int RATE_CYC  = 16,
  parameter int STEP      = 4,
  parameter int MON_CYC   = 32,
  parameter int POS_TH    = 1000,
  parameter int NEG_TH    = -1000,
  parameter int MON_LIMIT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_data,
  input  logic [2:0]           filt_sel,
  input  logic                 self_test,
  output logic                 init_done,
  output logic signed [DW-1:0] ofs_applied,
  output logic                 off_err
);
  localparam int SIW = $clog2(NSET);
  localparam logic signed [DW:0] HI = (DW+1)'((1 << (DW - 1)) - 1);
  localparam logic signed [DW:0] LO = -HI - 1;

  phase_e               phase;
  logic                 rate_tick, mon_tick, take, limit_en;
  logic [SIW-1:0]       set_idx;
  logic signed [DW-1:0] est, ofs;
  logic signed [DW:0]   diff;
  logic signed [DW-1:0] diff_sat;
  logic                 ov_q;
  logic signed [DW-1:0] od_q;

  offset_phase_ctl #(
    .PH1(PH1), .PH2(PH2), .RATE_CYC(RATE_CYC), .MON_CYC(MON_CYC)
  ) u_ctl (
    .clk(clk), .rst(rst), .phase(phase), .rate_tick(rate_tick), .mon_tick(mon_tick)
  );

  always_comb begin
    case (phase)
      PH_FAST1: set_idx = SIW'(0);
      PH_FAST2: set_idx = SIW'(1);
      default:  set_idx = SIW'(2 + int'(filt_sel[2:1]));
    endcase
  end

  assign limit_en  = (phase == PH_RUN) && filt_sel[0];
  assign init_done = (phase == PH_RUN);

  assign in_ready = !ov_q || out_ready;
  assign take     = in_valid && in_ready;

  offset_iir #(
    .DW(DW), .CWID(CWID), .FRAC(FRAC), .NSET(NSET), .N1(N1), .N2(N2), .D2(D2)
  ) u_iir (
    .clk(clk), .rst(rst), .smp_en(take), .x_in(in_data), .set_idx(set_idx), .y_out(est)
  );

  offset_apply #(.DW(DW), .STEP(STEP)) u_apply (
    .clk(clk), .rst(rst), .est(est), .hold(self_test), .limit_en(limit_en),
    .rate_tick(rate_tick), .ofs(ofs)
  );

  offset_monitor #(
    .DW(DW), .POS_TH(POS_TH), .NEG_TH(NEG_TH), .LIMIT(MON_LIMIT)
  ) u_mon (
    .clk(clk), .rst(rst), .tick(mon_tick), .ofs(ofs), .err(off_err)
  );

  always_comb begin
    diff = {in_data[DW-1], in_data} - {ofs[DW-1], ofs};
    if (diff > HI)      diff_sat = HI[DW-1:0];
    else if (diff < LO) diff_sat = LO[DW-1:0];
    else                diff_sat = diff[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else if (take) begin
      ov_q <= 1'b1;
      od_q <= diff_sat;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid   = ov_q;
  assign out_data    = od_q;
  assign ofs_applied = ofs;
endmodule

// File: rtl/offset_loop_chk.sv
module offset_loop_chk #(
  parameter int DW   = 16,
  parameter int STEP = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_data,
  input logic [2:0]           filt_sel,
  input logic                 self_test,
  input logic                 init_done,
  input logic signed [DW-1:0] ofs_applied,
  input logic                 off_err
);
  logic signed [DW+1:0] ofs_w;
  assign ofs_w = {{2{ofs_applied[DW-1]}}, ofs_applied};

  p_backpressure_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_init_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (init_done && filt_sel[0] && !self_test) |=>
      ((ofs_w - $past(ofs_w)) <= STEP && ($past(ofs_w) - ofs_w) <= STEP));

  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    self_test |=> $stable(ofs_applied));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    off_err |=> off_err);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && ofs_applied == '0 && !off_err && !init_done));
endmodule

bind offset_loop offset_loop_chk #(.DW(DW), .STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .filt_sel(filt_sel),
  .self_test(self_test), .init_done(init_done), .ofs_applied(ofs_applied),
  .off_err(off_err)
);

// File: tb/sim_offset_loop.sv
module sim_offset_loop;
  localparam int CLK_PERIOD = 10;
  localparam int PH1 = 400;
  localparam int PH2 = 200;
  localparam int MONP = 32;
  localparam int NV = 12;
  localparam int VEC [NV][2] = '{
    '{100, 100}, '{100, 50}, '{-50, -150}, '{200, 175}, '{0, -75}, '{1000, 900},
    '{-1000, -1500}, '{7, 7}, '{-1, 496}, '{-32768, -32768}, '{32767, 32767}, '{0, 1}
  };
  localparam int AVAL [6] = '{128, 64, 32, 16, 8, 128};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic self_test = 1'b0;
  logic [2:0] filt_sel = 3'b110;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid, init_done, off_err;
  logic signed [15:0] out_data, ofs_applied;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  int m_xp = 0;
  int m_yp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  offset_loop u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .filt_sel(filt_sel), .self_test(self_test), .init_done(init_done),
    .ofs_applied(ofs_applied), .off_err(off_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cur_set();
    if (cyc < PH1) return 0;
    if (cyc < PH1 + PH2) return 1;
    return 2 + int'(filt_sel[2:1]);
  endfunction

  task automatic model(input int x);
    int a = AVAL[cur_set()];
    int y = (a * x + a * m_xp - (2 * a - 256) * m_yp) >>> 8;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    m_xp = x;
    m_yp = y;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    m_xp = 0;
    m_yp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input int x, output int got);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 16'(x);
    model(x);
    @(negedge clk);
    in_valid = 1'b0;
    got = int'(out_data);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_chk(input int x, input string req);
    int exp = x - m_yp;
    int got;
    if (exp > 32767) exp = 32767;
    if (exp < -32768) exp = -32768;
    send(x, got);
    chk(got == exp, req, got, exp);
  endtask

  initial begin
    int got;
    int prev;
    int changes;
    int badstep;

    // Run A
    do_reset();
    @(negedge clk);
    chk(!out_valid && in_ready && ofs_applied == 0 && !init_done && !off_err,
        "R9 reset state", int'(ofs_applied), 0);
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][0], got);
      chk(got == VEC[i][1], "R2 R3 table vector", got, VEC[i][1]);
    end
    // R1 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_data = 16'sd5;
    model(5);
    @(negedge clk);
    chk(out_valid && int'(out_data) == -16378, "R1 first result", int'(out_data), -16378);
    in_data = 16'sd9;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!in_ready && int'(out_data) == -16378, "R1 hold under back-pressure",
          int'(out_data), -16378);
    end
    out_ready = 1'b1;
    model(9);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && int'(out_data) == 7, "R1 pending sample after release",
        int'(out_data), 7);
    repeat (2) @(negedge clk);
    // R4 phase two coefficients
    while (cyc < PH1 + 10) @(negedge clk);
    send_chk(300, "R4 phase2 sample");
    send_chk(300, "R4 phase2 sample");
    send_chk(-200, "R4 phase2 sample");
    send_chk(1234, "R4 phase2 sample");
    while (cyc < PH1 + PH2 - 1) @(negedge clk);
    chk(!init_done, "R4 init_done before end", int'(init_done), 0);
    @(negedge clk);
    chk(init_done, "R4 init_done at end", int'(init_done), 1);
    filt_sel = 3'b000;
    send_chk(400, "R4 normal select 0");
    send_chk(400, "R4 normal select 0");
    send_chk(-300, "R4 normal select 0");
    filt_sel = 3'b100;
    send_chk(2000, "R4 normal select 2");
    send_chk(2000, "R4 normal select 2");
    chk(int'(ofs_applied) == m_yp, "R5 direct applied offset", int'(ofs_applied), m_yp);

    // Run B: self-test from reset, then rate limiting
    self_test = 1'b1;
    filt_sel = 3'b110;
    do_reset();
    send(1000, got);
    chk(got == 1000, "R7 hp with frozen offset", got, 1000);
    send(1000, got);
    chk(got == 1000 && ofs_applied == 0, "R7 offset frozen in startup",
        int'(ofs_applied), 0);
    while (cyc < PH1 + PH2 - 1) @(negedge clk);
    chk(!init_done && ofs_applied == 0, "R7 timer before end", int'(init_done), 0);
    @(negedge clk);
    chk(init_done, "R7 timers ran during self-test", int'(init_done), 1);
    self_test = 1'b0;
    repeat (2) @(negedge clk);
    chk(int'(ofs_applied) == m_yp, "R5 offset follows after release",
        int'(ofs_applied), m_yp);
    filt_sel = 3'b111;
    send(8000, got);
    send(8000, got);
    prev = int'(ofs_applied);
    changes = 0;
    badstep = 0;
    for (int k = 0; k < 160; k++) begin
      @(negedge clk);
      if (int'(ofs_applied) != prev) begin
        changes++;
        if (int'(ofs_applied) - prev != 4) badstep++;
        prev = int'(ofs_applied);
      end
    end
    chk(changes == 10, "R6 one change per rate period", changes, 10);
    chk(badstep == 0, "R6 step size", badstep, 0);
    self_test = 1'b1;
    prev = int'(ofs_applied);
    repeat (64) @(negedge clk);
    chk(int'(ofs_applied) == prev, "R7 freeze in rate mode", int'(ofs_applied), prev);
    self_test = 1'b0;
    filt_sel = 3'b110;
    repeat (2) @(negedge clk);
    chk(int'(ofs_applied) == 8000, "R5 direct after rate mode", int'(ofs_applied), 8000);

    // Run C: offset monitor
    do_reset();
    send(-5000, got);
    send(-5000, got);
    chk(int'(ofs_applied) == -5000, "R8 negative offset applied", int'(ofs_applied), -5000);
    repeat (20 * MONP) @(negedge clk);
    chk(!off_err, "R8 no error while negative", int'(off_err), 0);
    send(5000, got);
    send(5000, got);
    repeat (6 * MONP) @(negedge clk);
    chk(!off_err, "R8 counter floored at zero", int'(off_err), 0);
    repeat (4 * MONP) @(negedge clk);
    chk(off_err, "R8 error at limit", int'(off_err), 1);
    send(-5000, got);
    send(-5000, got);
    repeat (20 * MONP) @(negedge clk);
    chk(off_err, "R8 error sticky", int'(off_err), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule